// File: doc/BRIEF.md
# Multiplexed-Address Machine Cycle Sequencer

This block produces the bus timing of a small 8-bit processor whose 16-bit memory address leaves the chip over eight shared address lines. Each machine cycle lasts eight clock periods, numbered 0 to 7. In every cycle the block drives the upper address byte first and the lower byte afterwards. It raises an early timing pulse so that outside logic can latch the upper byte. It raises a late timing pulse near the end of the cycle. It also drives an active-low read strobe, an active-low write strobe, write data with an output enable, and a 2-bit code that names the kind of cycle in progress.

Work arrives as a stream of instruction commands. Each command carries:
- the fetch address,
- the execute address,
- a "long" flag, which selects three machine cycles (one fetch and two executes) instead of two,
- a write flag,
- the write data.

A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The fetch cycle of that command starts in the next clock. `cmd_ready` is high only while the sequencer is idle or in period 7 of the final cycle of the current instruction, and only while `hold` is low. This lets a new command follow the current one with no gap. While `cmd_valid` is low, the sequencer waits idle, and the command fields may change freely.

Top module: `mcyc_sequencer`

## Requirements
- R1: After a synchronous active-high reset, and whenever the sequencer is idle, all of the following hold: `ma` = 0, `tpa` = `tpb` = 0, `mrd_n` = `mwr_n` = 1, `data_oe` = 0, `state_code` = 2'b00 and `cmd_ready` = 1.
- R2: A machine cycle lasts exactly 8 clock periods, numbered 0 to 7. `tpa` is high in period 1 only and `tpb` is high in period 6 only.
- R3: `ma` carries bits 15:8 of the cycle address in periods 0 to 2 and bits 7:0 in periods 3 to 7.
- R4: The cycle address is `cmd_fetch_addr` in the fetch cycle and `cmd_exec_addr` in the first execute cycle. In the second execute cycle it is `cmd_exec_addr` + 1, taken modulo 65,536.
- R5: A command with `cmd_long` = 0 runs one fetch cycle and one execute cycle. A command with `cmd_long` = 1 runs one fetch cycle and two execute cycles. After its last cycle the sequencer goes idle unless a new command is accepted.
- R6: `state_code` is 2'b00 during fetch cycles and 2'b01 during execute cycles.
- R7: `mrd_n` is 0 for all 8 periods of every read cycle and 1 throughout a write cycle. The fetch cycle is always a read. An execute cycle is a read unless it is a write cycle.
- R8: Only the execute cycle of a command with `cmd_write` = 1 and `cmd_long` = 0 is a write cycle. In that cycle `mwr_n` is 0 in periods 5 and 6 only. For a long command, `cmd_write` has no effect.
- R9: In a write cycle, `data_oe` is 1 and `data_out` equals the command's `cmd_wdata` in periods 4 to 7. In all other periods `data_oe` is 0.
- R10: While `hold` is 1, the period, the cycle and every output except `cmd_ready` keep their values.
- R11: `cmd_ready` is 1 exactly when `hold` is 0 and the sequencer is either idle or in period 7 of its last cycle. A command accepted in that period 7 starts its fetch period 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes the sequencer while high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge if valid |
| cmd_long | input | 1 | Three-cycle instruction |
| cmd_write | input | 1 | Execute cycle is a memory write |
| cmd_fetch_addr | input | 16 | Fetch cycle address |
| cmd_exec_addr | input | 16 | First execute cycle address |
| cmd_wdata | input | 8 | Data for the write cycle |
| ma | output | 8 | Multiplexed address lines |
| tpa | output | 1 | Upper-byte latch pulse, period 1 |
| tpb | output | 1 | Late pulse, period 6 |
| mrd_n | output | 1 | Read strobe, active low |
| mwr_n | output | 1 | Write strobe, active low |
| data_out | output | 8 | Write data |
| data_oe | output | 1 | Write data enable |
| state_code | output | 2 | 00 fetch, 01 execute |

## Verification
The bench checks every output in every period of every cycle of each command kind. It targets the following corner cases:
- The second execute address of a long command, where the increment must carry into the upper byte (0x00FF to 0x0100). A design without the carry would drive 0x00 as the upper byte.
- A long command that also has its write flag set. A design that honoured the flag would pulse `mwr_n` and release `mrd_n`.
- A `hold` placed inside the write strobe, on the latch pulse, and on the last period with a command chained behind it. A sequencer that kept counting, or that accepted the chained command early, would shorten the strobe or lose a cycle.
- Back-to-back commands. An off-by-one in the handover would insert an idle clock or skip fetch period 0.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    SC_FETCH = 2'b00,
    SC_EXEC  = 2'b01,
    SC_DMA   = 2'b10,
    SC_INT   = 2'b11
  } sc_e;

  localparam int unsigned MAX_CYC = 3;  // fetch + two executes
endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
  parameter int unsigned PERIODS = 8,
  localparam int unsigned PH_W = $clog2(PERIODS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            run,
  output logic [PH_W-1:0] phase,
  output logic            ph_last
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIODS - 1);

  assign ph_last = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (hold)    phase <= phase;
    else if (!run)    phase <= '0;
    else if (ph_last) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  a_r10_hold_freezes_phase: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(phase)) else $error("R10 phase moved under hold");

  a_r2_phase_wraps: assert property (@(posedge clk) disable iff (rst)
    (ph_last && !hold) |=> (phase == '0)) else $error("R2 phase did not wrap");
endmodule

// File: rtl/mcs_cycle_seq.sv
module mcs_cycle_seq
  import mcs_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          ph_last,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_long,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_fetch_addr,
  input  logic [AW-1:0] cmd_exec_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          active,
  output logic [AW-1:0] cur_addr,
  output logic          rd_cycle,
  output logic          wr_cycle,
  output logic [DW-1:0] wdata,
  output sc_e           sc
);
  localparam int unsigned IDX_W = $clog2(MAX_CYC);

  logic [IDX_W-1:0] idx;
  logic             l_long, l_write;
  logic [AW-1:0]    l_fa, l_ea;
  logic [DW-1:0]    l_wd;
  logic             last_cyc, accept;

  assign last_cyc  = (idx == (l_long ? IDX_W'(2) : IDX_W'(1)));
  assign cmd_ready = !hold && (!active || (ph_last && last_cyc));
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      l_long  <= 1'b0;
      l_write <= 1'b0;
      l_fa    <= '0;
      l_ea    <= '0;
      l_wd    <= '0;
    end else if (!hold) begin
      if (accept) begin
        active  <= 1'b1;
        idx     <= '0;
        l_long  <= cmd_long;
        l_write <= cmd_write;
        l_fa    <= cmd_fetch_addr;
        l_ea    <= cmd_exec_addr;
        l_wd    <= cmd_wdata;
      end else if (active && ph_last) begin
        if (last_cyc) begin
          active <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign cur_addr = (idx == '0) ? l_fa : (l_ea + AW'(idx == IDX_W'(2)));
  assign wr_cycle = active && (idx == IDX_W'(1)) && l_write && !l_long;
  assign rd_cycle = active && !wr_cycle;
  assign wdata    = l_wd;
  assign sc       = (!active || idx == '0) ? SC_FETCH : SC_EXEC;

  a_r5_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (!l_long |-> idx <= IDX_W'(1)) && (idx <= IDX_W'(2)))
    else $error("R5 cycle index out of range");

  a_r11_no_ready_in_hold: assert property (@(posedge clk) disable iff (rst)
    hold |-> !cmd_ready) else $error("R11 ready during hold");

  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    (sc == SC_FETCH) || (sc == SC_EXEC)) else $error("R6 bad state code");
endmodule

// File: rtl/mcs_bus_drive.sv
module mcs_bus_drive #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned PERIODS   = 8,
  parameter int unsigned TPA_AT    = 1,
  parameter int unsigned TPB_AT    = 6,
  parameter int unsigned HI_LAST   = 2,
  parameter int unsigned WR_FIRST  = 5,
  parameter int unsigned WR_LAST   = 6,
  parameter int unsigned DOE_FIRST = 4,
  localparam int unsigned PH_W = $clog2(PERIODS),
  localparam int unsigned MW   = AW / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  input  logic            rd_cycle,
  input  logic            wr_cycle,
  input  logic [AW-1:0]   cur_addr,
  input  logic [DW-1:0]   wdata,
  output logic [MW-1:0]   ma,
  output logic            tpa,
  output logic            tpb,
  output logic            mrd_n,
  output logic            mwr_n,
  output logic [DW-1:0]   data_out,
  output logic            data_oe
);
  logic in_wr_win, in_doe_win, hi_half;

  assign hi_half    = (phase <= PH_W'(HI_LAST));
  assign in_wr_win  = (phase >= PH_W'(WR_FIRST)) && (phase <= PH_W'(WR_LAST));
  assign in_doe_win = (phase >= PH_W'(DOE_FIRST));

  always_comb begin
    ma = '0;
    if (active) ma = hi_half ? cur_addr[AW-1:MW] : cur_addr[MW-1:0];
  end

  assign tpa      = active && (phase == PH_W'(TPA_AT));
  assign tpb      = active && (phase == PH_W'(TPB_AT));
  assign mrd_n    = !rd_cycle;
  assign mwr_n    = !(wr_cycle && in_wr_win);
  assign data_oe  = wr_cycle && in_doe_win;
  assign data_out = data_oe ? wdata : '0;

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mrd_n && !mwr_n)) else $error("R7 both strobes active");

  a_r8_wr_window: assert property (@(posedge clk) disable iff (rst)
    !mwr_n |-> (phase == PH_W'(WR_FIRST) || phase == PH_W'(WR_LAST)))
    else $error("R8 write strobe outside window");

  a_r9_data_covers_strobe: assert property (@(posedge clk) disable iff (rst)
    !mwr_n |-> data_oe) else $error("R9 strobe without data");

  a_r2_pulses_apart: assert property (@(posedge clk) disable iff (rst)
    !(tpa && tpb)) else $error("R2 pulses overlap");
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned PERIODS = 8,
  localparam int unsigned MW     = AW / 2,
  localparam int unsigned PH_W   = $clog2(PERIODS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_long,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_fetch_addr,
  input  logic [AW-1:0] cmd_exec_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic [MW-1:0] ma,
  output logic          tpa,
  output logic          tpb,
  output logic          mrd_n,
  output logic          mwr_n,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [1:0]    state_code
);
  logic            active, ph_last, rd_cycle, wr_cycle;
  logic [PH_W-1:0] phase;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   wdata;
  sc_e             sc;

  mcs_phase_ctr #(.PERIODS(PERIODS)) u_ph (
    .clk(clk), .rst(rst), .hold(hold), .run(active),
    .phase(phase), .ph_last(ph_last)
  );

  mcs_cycle_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .hold(hold), .ph_last(ph_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_long(cmd_long), .cmd_write(cmd_write),
    .cmd_fetch_addr(cmd_fetch_addr), .cmd_exec_addr(cmd_exec_addr),
    .cmd_wdata(cmd_wdata), .active(active), .cur_addr(cur_addr),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .wdata(wdata), .sc(sc)
  );

  mcs_bus_drive #(.AW(AW), .DW(DW), .PERIODS(PERIODS)) u_bus (
    .clk(clk), .rst(rst), .active(active), .phase(phase),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .cur_addr(cur_addr),
    .wdata(wdata), .ma(ma), .tpa(tpa), .tpb(tpb), .mrd_n(mrd_n),
    .mwr_n(mwr_n), .data_out(data_out), .data_oe(data_oe)
  );

  assign state_code = sc;

  a_r10_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(ma) && $stable(tpa) && $stable(mrd_n) && $stable(mwr_n)))
    else $error("R10 outputs moved under hold");

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> (mrd_n && mwr_n && !data_oe && ma == '0))
    else $error("R1 idle bus not quiet");
endmodule

// File: tb/sim_mcyc_sequencer.sv
module sim_mcyc_sequencer;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, hold = 1'b0, cmd_valid = 1'b0;
  logic cmd_long = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_fetch_addr = '0, cmd_exec_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, tpa, tpb, mrd_n, mwr_n, data_oe;
  logic [7:0]  ma, data_out;
  logic [1:0]  state_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  mcyc_sequencer u0 (
    .clk(clk), .rst(rst), .hold(hold), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_long(cmd_long), .cmd_write(cmd_write),
    .cmd_fetch_addr(cmd_fetch_addr), .cmd_exec_addr(cmd_exec_addr),
    .cmd_wdata(cmd_wdata), .ma(ma), .tpa(tpa), .tpb(tpb), .mrd_n(mrd_n),
    .mwr_n(mwr_n), .data_out(data_out), .data_oe(data_oe),
    .state_code(state_code)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({"R1 ma ", tag}, ma, 0);
    chk({"R1 tpa/tpb ", tag}, {tpa, tpb}, 0);
    chk({"R1 strobes ", tag}, {mrd_n, mwr_n}, 3);
    chk({"R1 data_oe ", tag}, data_oe, 0);
    chk({"R1 state_code ", tag}, state_code, 0);
    chk({"R1 ready ", tag}, cmd_ready, 1);
  endtask

  // expected port values computed from the requirements
  task automatic chk_period(input bit l, input bit w, input logic [15:0] fa,
                            input logic [15:0] ea, input logic [7:0] wd,
                            input int cyc, input int p);
    logic [15:0] a;
    bit wr;
    a  = (cyc == 0) ? fa : ((cyc == 2) ? ea + 16'd1 : ea);  // R4
    wr = (cyc == 1) && w && !l;                              // R8
    chk("R3 R4 address byte", ma, (p <= 2) ? a[15:8] : a[7:0]);
    chk("R2 tpa", tpa, (p == 1) ? 1 : 0);
    chk("R2 tpb", tpb, (p == 6) ? 1 : 0);
    chk("R6 state_code", state_code, (cyc == 0) ? 0 : 1);
    chk("R7 mrd_n", mrd_n, wr ? 1 : 0);
    chk("R8 mwr_n", mwr_n, (wr && (p == 5 || p == 6)) ? 0 : 1);
    chk("R9 data_oe", data_oe, (wr && p >= 4) ? 1 : 0);
    if (wr && p >= 4) chk("R9 data_out", data_out, wd);
  endtask

  task automatic present(input bit l, input bit w, input logic [15:0] fa,
                         input logic [15:0] ea, input logic [7:0] wd);
    cmd_long = l; cmd_write = w; cmd_fetch_addr = fa;
    cmd_exec_addr = ea; cmd_wdata = wd; cmd_valid = 1'b1;
  endtask

  // entered just after the accepting edge; leaves at the last period's negedge
  task automatic run_instr(input bit l, input bit w, input logic [15:0] fa,
                           input logic [15:0] ea, input logic [7:0] wd,
                           input int hc, input int hp, input bit chain,
                           input bit nl, input bit nw, input logic [15:0] nfa,
                           input logic [15:0] nea, input logic [7:0] nwd);
    int ncyc;
    ncyc = l ? 3 : 2;  // R5
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      for (int p = 0; p < 8; p++) begin
        bit last;
        last = (cyc == ncyc - 1) && (p == 7);
        @(negedge clk);
        if (cyc == 0 && p == 0) cmd_valid = 1'b0;
        chk_period(l, w, fa, ea, wd, cyc, p);
        if (cyc == hc && p == hp) begin
          hold = 1'b1; #1;
          chk("R10 R11 ready low under hold", cmd_ready, 0);
          @(negedge clk);
          chk_period(l, w, fa, ea, wd, cyc, p);  // R10 frozen
          hold = 1'b0; #1;
        end
        chk("R11 cmd_ready", cmd_ready, last ? 1 : 0);
        if (last && chain) present(nl, nw, nfa, nea, nwd);
      end
    end
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk_idle("after reset");
    // R10 hold while idle leaves it idle
    hold = 1'b1; @(negedge clk); chk("R10 R11 idle ready under hold", cmd_ready, 0);
    hold = 1'b0; #1;

    // short read
    present(1'b0, 1'b0, 16'h12A5, 16'h3C0F, 8'h00);
    @(posedge clk);
    run_instr(1'b0, 1'b0, 16'h12A5, 16'h3C0F, 8'h00, -1, -1, 1'b0, 0, 0, 0, 0, 0);
    @(negedge clk); chk_idle("after short read R5");

    // short write with hold inside write strobe
    present(1'b0, 1'b1, 16'h4400, 16'hBEEF, 8'h9E);
    @(posedge clk);
    run_instr(1'b0, 1'b1, 16'h4400, 16'hBEEF, 8'h9E, 1, 5, 1'b0, 0, 0, 0, 0, 0);
    @(negedge clk); chk_idle("after write R5");

    // long with write flag (ignored), carry on second execute, hold on tpa
    present(1'b1, 1'b1, 16'hFFFE, 16'h00FF, 8'h55);
    @(posedge clk);
    run_instr(1'b1, 1'b1, 16'hFFFE, 16'h00FF, 8'h55, 0, 1, 1'b0, 0, 0, 0, 0, 0);
    @(negedge clk); chk_idle("after long R5 R8");

    // back-to-back: write then long read, hold on handover period
    present(1'b0, 1'b1, 16'h0102, 16'h8081, 8'hC3);
    @(posedge clk);
    run_instr(1'b0, 1'b1, 16'h0102, 16'h8081, 8'hC3, 1, 7, 1'b1,
              1'b1, 1'b0, 16'h7F80, 16'hA5FF, 8'h00);
    @(posedge clk);
    run_instr(1'b1, 1'b0, 16'h7F80, 16'hA5FF, 8'h00, 2, 6, 1'b0, 0, 0, 0, 0, 0);
    @(negedge clk); chk_idle("after chain R11");

    // sweep of all four command kinds, each chained into the next
    present(1'b0, 1'b0, 16'h0000, 16'hFFFF, 8'h11);
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      bit l, w, nl, nw;
      logic [15:0] fa, ea;
      l = k[1]; w = k[0]; nl = (k + 1) >> 1; nw = (k + 1) & 1;
      fa = 16'(k * 16'h1111);
      ea = 16'hFFFF - 16'(k * 16'h0101);
      run_instr(l, w, fa, ea, 8'(8'h11 * (k + 1)), -1, -1, (k < 3),
                nl, nw, 16'((k + 1) * 16'h1111),
                16'hFFFF - 16'((k + 1) * 16'h0101), 8'(8'h11 * (k + 2)));
      if (k < 3) @(posedge clk);
    end
    @(negedge clk); chk_idle("after sweep R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule